// File: doc/BRIEF.md
# Display-Side Link Receiver with Write Strobes

This block sits at the display end of a serial link. It waits in a standby state until a wake input reports serial activity. It then shifts in one frame, one bit per clock. The first bit of every frame tells it whether the transaction is a write or a read.

A write frame carries a strobe-select bit, six control bits and eighteen data bits. The block drives the control and data fields onto its parallel outputs. It then pulses one of two active-low write clocks, chosen by the strobe-select bit. Each pulse is low for a fixed number of cycles and ends with a rising edge.

A read-control frame is only eight bits long. On a read, the block drives the control outputs and stops driving the data bus. After one idle cycle on the serial line, it takes the selected write clock low, which lets the display put its data on the bus. The block captures that data on the rising edge it generates itself. It then sends a 26-bit reply frame in which the header field is all zeros and the display's data follows. Finally it releases the serial line and goes back to standby.

Top module: `lnk_slave_rx`

## Requirements
- R1: After reset, both write clocks are high, the serial output is not driven (`ser_oe` = 0, `ser_out` = 0), `dp_drive` = 1, and `ctrl_out` and `dp_out` are zero.
- R2: A frame starts in the cycle after `link_wake` is seen high in standby. From then on one bit is taken from `ser_in` per cycle in this order: bit 0 is read/write (1 = read), bit 1 is strobe-select, bits 2..7 are `ctrl_out[0..5]`, and bits 8..25 are `dp_out[0..17]`.
- R3: A write frame (bit 0 = 0) is 26 bits long. At the clock edge that samples bit 25, `ctrl_out` and `dp_out` take the received values. From that edge on, `wclk0` (strobe-select 0) or `wclk1` (strobe-select 1) stays low for exactly LOW_CYC cycles, while the other write clock stays high.
- R4: A read-control frame (bit 0 = 1) is 8 bits long. At the edge that samples bit 7, `ctrl_out` is updated and `dp_drive` goes low. `dp_drive` stays low until the reply frame has been sent.
- R5: After a read-control frame, the line stays idle for one cycle. The selected write clock is then low for LOW_CYC cycles. `dp_in` is sampled at the edge where that clock rises, so only the value present in the last low cycle counts.
- R6: The reply frame starts on the clock edge where the write clock rises. `ser_oe` is high for 26 cycles: first eight zero bits, then `dp_in[0..17]`, lowest bit first.
- R7: After the reply, `ser_oe` and `ser_out` go low and `dp_drive` returns high. One cycle later the block is back in standby and accepts a new frame.
- R8: `link_wake` has no effect while a frame is being received or processed.
- R9: `dp_out` keeps its last written value throughout a read transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| link_wake | input | 1 | Activity detected on the link; starts a frame in standby |
| ser_in | input | 1 | Received serial bit |
| ser_out | output | 1 | Reply serial bit |
| ser_oe | output | 1 | High while the block drives the serial line |
| ctrl_out | output | 6 | Received control field |
| dp_out | output | 18 | Received data field from the last write |
| dp_drive | output | 1 | High when the data bus is driven; low (high impedance) in a read |
| dp_in | input | 18 | Data placed on the bus by the display during a read |
| wclk0 | output | 1 | Write clock 0, active low |
| wclk1 | output | 1 | Write clock 1, active low |

## Verification
A receive index that is off by one shows up at once as shifted control and data fields, at the edge that ends the frame. A miscounted strobe timer shows up as a low window that is one cycle too short or too long. A capture taken on the wrong cycle returns the decoy value the bench drives early in the window. A wrong reply length or header shows in the collected serial bits and in the `ser_oe` window. A state that never leaves the read phase holds `dp_drive` low and breaks the next transaction that follows directly.

// File: rtl/lnk_pkg.sv
package lnk_pkg;
    localparam int LNK_CTRL_W = 6;
    localparam int LNK_DATA_W = 18;
    localparam int LNK_HDR_W  = 2 + LNK_CTRL_W;
    localparam int LNK_FRM_W  = LNK_HDR_W + LNK_DATA_W;
    localparam int LNK_IDX_W  = $clog2(LNK_FRM_W);

    typedef enum logic [2:0] {
        ST_STBY, ST_RECV, ST_WLOW, ST_RTURN, ST_RLOW, ST_SEND, ST_REL
    } lnk_state_e;

    // Packed so that bit 0 is the first bit on the line.
    typedef struct packed {
        logic [LNK_DATA_W-1:0] dp;
        logic [LNK_CTRL_W-1:0] ctrl;
        logic                  sel;
        logic                  rd;
    } lnk_frame_t;

    function automatic lnk_frame_t reply_frame(input logic [LNK_DATA_W-1:0] d);
        lnk_frame_t r;
        r    = '0;
        r.dp = d;
        return r;
    endfunction
endpackage

// File: rtl/lnk_rx.sv
module lnk_rx
    import lnk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 bit_in,
    output logic [LNK_FRM_W-1:0] next_frm,
    output logic [LNK_IDX_W-1:0] idx
);
    logic [LNK_FRM_W-1:0] frm;

    always_comb begin
        next_frm      = frm;
        next_frm[idx] = bit_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            frm <= '0;
            idx <= '0;
        end else begin
            frm <= next_frm;
            idx <= idx + 1'b1;
        end
    end
endmodule

// File: rtl/lnk_strobe.sv
module lnk_strobe #(
    parameter int LOW_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       sel,
    output logic [1:0] wclk,
    output logic       last
);
    localparam int CW = $clog2(LOW_CYC + 1);
    localparam logic [CW-1:0] CNT_END = CW'(LOW_CYC - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign last = active && (cnt == CNT_END);

    for (genvar g = 0; g < 2; g++) begin : g_wclk
        assign wclk[g] = !(active && (sel == 1'(g)));
    end
endmodule

// File: rtl/lnk_tx.sv
module lnk_tx
    import lnk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load,
    input  logic [LNK_FRM_W-1:0] load_frm,
    output logic                 ser_out,
    output logic                 ser_oe,
    output logic                 done
);
    localparam logic [LNK_IDX_W-1:0] LAST = LNK_IDX_W'(LNK_FRM_W - 1);

    logic [LNK_FRM_W-1:0] sh;
    logic [LNK_IDX_W-1:0] cnt;
    logic                 act;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh  <= '0;
            cnt <= '0;
            act <= 1'b0;
        end else if (load) begin
            sh  <= load_frm;
            cnt <= '0;
            act <= 1'b1;
        end else if (act) begin
            sh  <= sh >> 1;
            cnt <= cnt + 1'b1;
            if (cnt == LAST) act <= 1'b0;
        end
    end

    assign ser_oe  = act;
    assign ser_out = act & sh[0];
    assign done    = act && (cnt == LAST);
endmodule

// File: rtl/lnk_slave_rx.sv
module lnk_slave_rx
    import lnk_pkg::*;
#(
    parameter int LOW_CYC = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  link_wake,
    input  logic                  ser_in,
    output logic                  ser_out,
    output logic                  ser_oe,
    output logic [LNK_CTRL_W-1:0] ctrl_out,
    output logic [LNK_DATA_W-1:0] dp_out,
    output logic                  dp_drive,
    input  logic [LNK_DATA_W-1:0] dp_in,
    output logic                  wclk0,
    output logic                  wclk1
);
    localparam logic [LNK_IDX_W-1:0] HDR_LAST = LNK_IDX_W'(LNK_HDR_W - 1);
    localparam logic [LNK_IDX_W-1:0] FRM_LAST = LNK_IDX_W'(LNK_FRM_W - 1);

    lnk_state_e           state;
    logic                 sel_q;
    logic [LNK_FRM_W-1:0] nf_raw;
    lnk_frame_t           nf;
    logic [LNK_IDX_W-1:0] idx;
    logic [1:0]           wclk;
    logic                 strobe_last;
    logic                 tx_done;
    logic                 tx_load;

    lnk_rx u_rx (
        .clk(clk), .rst(rst), .en(state == ST_RECV), .bit_in(ser_in),
        .next_frm(nf_raw), .idx(idx)
    );
    assign nf = lnk_frame_t'(nf_raw);

    lnk_strobe #(.LOW_CYC(LOW_CYC)) u_strobe (
        .clk(clk), .rst(rst),
        .active(state == ST_WLOW || state == ST_RLOW),
        .sel(sel_q), .wclk(wclk), .last(strobe_last)
    );
    assign wclk0 = wclk[0];
    assign wclk1 = wclk[1];

    assign tx_load = (state == ST_RLOW) && strobe_last;

    lnk_tx u_tx (
        .clk(clk), .rst(rst), .load(tx_load), .load_frm(reply_frame(dp_in)),
        .ser_out(ser_out), .ser_oe(ser_oe), .done(tx_done)
    );

    assign dp_drive = !(state == ST_RTURN || state == ST_RLOW || state == ST_SEND);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_STBY;
            sel_q    <= 1'b0;
            ctrl_out <= '0;
            dp_out   <= '0;
        end else begin
            case (state)
                ST_STBY:  if (link_wake) state <= ST_RECV;
                ST_RECV: begin
                    if (idx == HDR_LAST && nf.rd) begin
                        ctrl_out <= nf.ctrl;
                        sel_q    <= nf.sel;
                        state    <= ST_RTURN;
                    end else if (idx == FRM_LAST) begin
                        ctrl_out <= nf.ctrl;
                        dp_out   <= nf.dp;
                        sel_q    <= nf.sel;
                        state    <= ST_WLOW;
                    end
                end
                ST_WLOW:  if (strobe_last) state <= ST_STBY;
                ST_RTURN: state <= ST_RLOW;
                ST_RLOW:  if (strobe_last) state <= ST_SEND;
                ST_SEND:  if (tx_done) state <= ST_REL;
                ST_REL:   state <= ST_STBY;
                default:  state <= ST_STBY;
            endcase
        end
    end

    assert_one_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        wclk0 || wclk1);
    assert_bus_released_R4: assert property (@(posedge clk) disable iff (rst)
        ser_oe |-> !dp_drive);
    assert_reply_on_rise_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_oe) |-> ($rose(wclk0) || $rose(wclk1)));
    assert_quiet_line_R7: assert property (@(posedge clk) disable iff (rst)
        !ser_oe |-> !ser_out);
    assert_release_bus_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_oe) |-> dp_drive);
    assert_dp_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!dp_drive && $past(!dp_drive)) |-> $stable(dp_out));
endmodule

// File: tb/lnk_slave_rx_test.sv
module lnk_slave_rx_test;
    localparam int W = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        link_wake = 1'b0;
    logic        ser_in = 1'b0;
    logic        ser_out, ser_oe, dp_drive, wclk0, wclk1;
    logic [5:0]  ctrl_out;
    logic [17:0] dp_out;
    logic [17:0] dp_in = '0;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    lnk_slave_rx #(.LOW_CYC(W)) uut (
        .clk(clk), .rst(rst), .link_wake(link_wake), .ser_in(ser_in),
        .ser_out(ser_out), .ser_oe(ser_oe), .ctrl_out(ctrl_out), .dp_out(dp_out),
        .dp_drive(dp_drive), .dp_in(dp_in), .wclk0(wclk0), .wclk1(wclk1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] wexp(input logic low, input logic sel);
        return low ? (sel ? 2'b01 : 2'b10) : 2'b11;
    endfunction

    task automatic do_write(input logic sel, input logic [5:0] c, input logic [17:0] d,
                            input logic hold_wake);
        logic [25:0] f;
        f = {d, c, sel, 1'b0};
        @(negedge clk); link_wake = 1'b1;
        for (int k = 0; k < 26; k++) begin
            @(negedge clk);
            link_wake = hold_wake && (k < 25);   // R8: held during receive
            ser_in = f[k];
        end
        @(negedge clk); ser_in = 1'b0; link_wake = 1'b0;
        chk("R3 ctrl_out", 32'(ctrl_out), 32'(c));
        chk("R2 dp_out order", 32'(dp_out), 32'(d));
        chk("R3 dp_drive", 32'(dp_drive), 32'd1);
        for (int i = 0; i < W; i++) begin
            if (i > 0) @(negedge clk);
            chk("R3 strobe low", 32'({wclk1, wclk0}), 32'(wexp(1'b1, sel)));
        end
        @(negedge clk);
        chk("R3 strobe end", 32'({wclk1, wclk0}), 32'd3);
        chk("R8 line idle", 32'(ser_oe), 32'd0);
    endtask

    task automatic do_read(input logic sel, input logic [5:0] c, input logic [17:0] d,
                           input logic [17:0] prev);
        logic [7:0]  f;
        logic [25:0] got;
        f = {c, sel, 1'b1};
        @(negedge clk); link_wake = 1'b1;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); link_wake = 1'b0; ser_in = f[k];
        end
        @(negedge clk); ser_in = 1'b0;
        chk("R4 ctrl_out", 32'(ctrl_out), 32'(c));
        chk("R4 dp_drive low", 32'(dp_drive), 32'd0);
        chk("R5 turnaround idle", 32'(ser_oe), 32'd0);
        chk("R5 no strobe yet", 32'({wclk1, wclk0}), 32'd3);
        for (int i = 0; i < W; i++) begin
            @(negedge clk);
            chk("R5 strobe low", 32'({wclk1, wclk0}), 32'(wexp(1'b1, sel)));
            chk("R9 dp_out held", 32'(dp_out), 32'(prev));
            dp_in = (i == W - 1) ? d : ~d;
        end
        for (int b = 0; b < 26; b++) begin
            @(negedge clk);
            chk("R6 ser_oe", 32'(ser_oe), 32'd1);
            if (b == 0) chk("R5 strobe risen", 32'({wclk1, wclk0}), 32'd3);
            got[b] = ser_out;
        end
        dp_in = 18'h0;
        chk("R6 reply frame", 32'(got), 32'({d, 8'h00}));
        @(negedge clk);
        chk("R7 line released", 32'({ser_oe, ser_out}), 32'd0);
        chk("R7 dp_drive back", 32'(dp_drive), 32'd1);
        chk("R9 dp_out after read", 32'(dp_out), 32'(prev));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [17:0] last_dp;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 wclk idle", 32'({wclk1, wclk0}), 32'd3);
        chk("R1 ser idle", 32'({ser_oe, ser_out}), 32'd0);
        chk("R1 dp_drive", 32'(dp_drive), 32'd1);
        chk("R1 outputs zero", 32'({ctrl_out, dp_out}), 32'd0);
        last_dp = '0;
        for (int s = 0; s < 2; s++) begin
            for (int p = 0; p < 6; p++) begin
                logic [17:0] d;
                logic [5:0]  c;
                d = 18'((p + 1) * 18'h0A5C3) ^ 18'(s << 17);
                c = 6'(p * 11 + s * 5);
                do_write(s[0], c, d, p == 3);
                last_dp = d;
                do_read(s[0], ~c, ~d ^ 18'(p), last_dp);
            end
        end
        do_write(1'b0, 6'h3F, 18'h3FFFF, 1'b0);
        do_read(1'b1, 6'h00, 18'h20001, 18'h3FFFF);
        do_read(1'b0, 6'h2A, 18'h00000, 18'h3FFFF);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule